// File: doc/BRIEF.md
# Multi-Mode BERT Pattern Generator

This block is the serial test-pattern source of a bit error rate tester. It emits one data bit at a time and steps to the next bit only on clock cycles where the bit-enable strobe is high. The strobe comes from channel gating outside the block, so the pattern can be spread over any set of bit slots. Three families of pattern are available: pseudorandom sequences of four lengths plus a zero-limited variant, a repeating pattern of 1 to 32 bits, and two 16-bit words that take turns after a programmable number of repetitions.

A single 32-bit pattern register is filled one byte at a time. In pseudorandom modes it provides the seed, in repeat mode it holds the pattern copied until it fills all 32 bits, and in alternating mode it holds the two words. The user writes the bytes, sets the mode controls, and then pulses the load input. The load restarts the generator from the register contents.

Top module: `bert_pattern_gen`

## Requirements
- R1: While reset is low, the pattern register, the shift state and all counters are cleared. After reset with mode 0 and prbsSel 0, dataOut is 0.
- R2: A write pulse with byteSel = b stores byteData into bits 8b+7..8b of the pattern register. In repeat and alternating modes, register bit 0 (the LSB of byte 0) is the first bit sent after a load. Bytes AD, B5, D6, 5A with length 5 give the sequence 1,0,1,1,0 repeating.
- R3: With mode 0 and prbsSel 0, 1, 2 or 3, the output is a maximal-length sequence of order n = 7, 9, 11 or 15. The tap t is 6, 5, 9 or 14. Register bits n-1..0 seed the state. The first n bits are register bits n-1 down to 0. After that, each bit o[k+n] equals o[k] XOR o[k+n-t]. With an all-ones seed, order 7 repeats every 127 bits and has 64 ones per period.
- R4: With mode 0 and prbsSel 4 to 7, the raw sequence follows the R3 rule with n = 20 and t = 17. Once 14 output bits in a row are zero, the next output bit is forced to 1. The output therefore never holds more than 14 consecutive zeros.
- R5: With mode 1, the output cycles through register bits 0 to patLen, so the pattern length is patLen+1, from 1 to 32 bits.
- R6: With mode 2, word A (register bits 15..0) and word B (bits 31..16) are each sent LSB first. N = altCount+1 copies of A are followed by N copies of B, and the cycle repeats, for N from 1 to 256.
- R7: A load pulse restarts the shift state, bit index and word counter from the current register and mode controls. It takes priority over a bit-enable in the same cycle. If a byte is written in the same cycle, the load uses the register contents from before that write.
- R8: On a cycle with bitEn and load both low, the generator state does not advance, and dataOut holds its value as long as the inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 pseudorandom, 1 repeat, 2 alternating words, 3 reserved (output 0) |
| prbsSel | input | 3 | 0..3 select order 7/9/11/15; 4..7 select zero-limited order 20 |
| patLen | input | 5 | Repeat length minus one |
| altCount | input | 8 | Word repetitions minus one for alternating mode |
| byteData | input | 8 | Byte written into the pattern register |
| byteSel | input | 2 | Byte position for the write |
| byteWr | input | 1 | Write strobe for one byte |
| load | input | 1 | Restarts the generator from the register contents |
| bitEn | input | 1 | Advances the sequence by one bit |
| dataOut | output | 1 | Current serial bit |

## Verification
dataOut is a combinational function of registered state and the mode inputs. A bit-enable or load sampled at a rising edge therefore shows its effect in the output right after that same edge, with no extra cycle of latency. Byte writes appear just as soon in the repeat and alternating modes. The bench model steps at each rising edge from the inputs the bench drove at the previous falling edge, and compares 5 ns after the edge, once the registers have settled. Targeted checks read the bit present at a falling edge before raising bitEn, so bit k of a capture is the k-th bit after the load.

// File: rtl/bert_pat_pkg.sv
package bert_pat_pkg;
  localparam int PAT_W      = 32;
  localparam int IDX_W      = $clog2(PAT_W);
  localparam int WORD_W     = 16;
  localparam int WORD_IDX_W = $clog2(WORD_W);
  localparam int LFSR_W     = 20;
  localparam int QRSS_RUN   = 14;
  localparam int RUN_W      = $clog2(QRSS_RUN + 1);

  typedef enum logic [1:0] {
    MODE_PRBS    = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_ALTWORD = 2'd2,
    MODE_NONE    = 2'd3
  } patMode_e;

  typedef struct packed {
    logic             reload;
    logic             shift;
    logic [IDX_W-1:0] bitIdx;
    logic             wordSel;
  } ctrlStrb_t;
endpackage

// File: rtl/bert_pat_ctrl.sv
module bert_pat_ctrl
  import bert_pat_pkg::*;
#(
  parameter int ALT_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic [IDX_W-1:0]     patLen,
  input  logic [ALT_CNT_W-1:0] altCount,
  input  logic                 load,
  input  logic                 bitEn,
  output ctrlStrb_t            strb
);
  localparam logic [IDX_W-1:0] WORD_LAST = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0]     bitIdx;
  logic [ALT_CNT_W-1:0] wordCnt;
  logic                 wordSel;
  logic [IDX_W-1:0]     lastIdx;
  logic                 idxWrap;
  logic                 advance;
  logic                 altMode;

  always_comb begin
    altMode = (patMode_e'(mode) == MODE_ALTWORD);
    lastIdx = altMode ? WORD_LAST : patLen;
    idxWrap = (bitIdx >= lastIdx);
    advance = bitEn && !load;
  end

  always_ff @(posedge clk) begin
    if (!rstN || load) begin
      bitIdx  <= '0;
      wordCnt <= '0;
      wordSel <= 1'b0;
    end else if (advance) begin
      bitIdx <= idxWrap ? '0 : bitIdx + IDX_W'(1);
      if (altMode && idxWrap) begin
        if (wordCnt >= altCount) begin
          wordCnt <= '0;
          wordSel <= ~wordSel;
        end else begin
          wordCnt <= wordCnt + ALT_CNT_W'(1);
        end
      end
    end
  end

  assign strb.reload  = load;
  assign strb.shift   = advance;
  assign strb.bitIdx  = bitIdx;
  assign strb.wordSel = wordSel;

  // R8: idle cycles leave the sequencing state untouched
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !load) |=> ($stable(bitIdx) && $stable(wordCnt) && $stable(wordSel)));

  // R7: a load returns the sequencing state to its start
  p_load_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (bitIdx == '0 && wordCnt == '0 && !wordSel));

  // R6: the word choice flips only at the last bit of a word
  p_word_flip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (advance && altMode && bitIdx != WORD_LAST) |=> $stable(wordSel));
endmodule

// File: rtl/bert_pat_datapath.sv
module bert_pat_datapath
  import bert_pat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic [2:0] prbsSel,
  input  logic [7:0] byteData,
  input  logic [1:0] byteSel,
  input  logic       byteWr,
  input  ctrlStrb_t  strb,
  output logic       dataOut
);
  localparam int NUM_BYTES = PAT_W / 8;

  logic [PAT_W-1:0]  patReg;
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrMask;
  logic [LFSR_W-1:0] lfsrNext;
  logic [RUN_W-1:0]  zeroRun;
  logic [4:0]        ord;
  logic [4:0]        tap;
  logic              isQrss;
  logic              rawBit;
  logic              prbsBit;
  logic              prbsMode;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) patReg[b*8 +: 8] <= '0;
      else if (byteWr && byteSel == 2'(b)) patReg[b*8 +: 8] <= byteData;
    end
  end

  always_comb begin
    case (prbsSel)
      3'd0:    begin ord = 5'd7;  tap = 5'd6;  end
      3'd1:    begin ord = 5'd9;  tap = 5'd5;  end
      3'd2:    begin ord = 5'd11; tap = 5'd9;  end
      3'd3:    begin ord = 5'd15; tap = 5'd14; end
      default: begin ord = 5'd20; tap = 5'd17; end
    endcase
    isQrss   = prbsSel[2];
    prbsMode = (patMode_e'(mode) == MODE_PRBS);
    lfsrMask = {LFSR_W{1'b1}} >> (5'(LFSR_W) - ord);
    rawBit   = lfsr[ord - 5'd1];
    lfsrNext = {lfsr[LFSR_W-2:0], rawBit ^ lfsr[tap - 5'd1]} & lfsrMask;
    prbsBit  = (isQrss && zeroRun == RUN_W'(QRSS_RUN)) ? 1'b1 : rawBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr    <= '0;
      zeroRun <= '0;
    end else if (strb.reload) begin
      lfsr    <= patReg[LFSR_W-1:0] & lfsrMask;
      zeroRun <= '0;
    end else if (strb.shift) begin
      lfsr <= lfsrNext;
      if (prbsMode && isQrss) zeroRun <= prbsBit ? '0 : zeroRun + RUN_W'(1);
      else                    zeroRun <= '0;
    end
  end

  always_comb begin
    case (patMode_e'(mode))
      MODE_PRBS:    dataOut = prbsBit;
      MODE_REPEAT:  dataOut = patReg[strb.bitIdx];
      MODE_ALTWORD: dataOut = patReg[{strb.wordSel, strb.bitIdx[WORD_IDX_W-1:0]}];
      default:      dataOut = 1'b0;
    endcase
  end

  // R7: a load seeds the shift state from the register held before the edge
  p_seed_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (lfsr == ($past(patReg[LFSR_W-1:0]) & $past(lfsrMask))));

  // R8: no shift without a strobe
  p_lfsr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shift && !strb.reload) |=> $stable(lfsr));

  // R4: a full zero run is broken by the next emitted bit
  p_qrss_break_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.reload && prbsMode && isQrss && zeroRun == RUN_W'(QRSS_RUN))
      |=> (zeroRun == '0));

  // R4: the zero-run count never passes its limit
  p_qrss_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    zeroRun <= RUN_W'(QRSS_RUN));
endmodule

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_pat_pkg::*;
#(
  parameter int ALT_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic [2:0]           prbsSel,
  input  logic [IDX_W-1:0]     patLen,
  input  logic [ALT_CNT_W-1:0] altCount,
  input  logic [7:0]           byteData,
  input  logic [1:0]           byteSel,
  input  logic                 byteWr,
  input  logic                 load,
  input  logic                 bitEn,
  output logic                 dataOut
);
  ctrlStrb_t strb;

  bert_pat_ctrl #(.ALT_CNT_W(ALT_CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .patLen(patLen),
    .altCount(altCount), .load(load), .bitEn(bitEn), .strb(strb)
  );

  bert_pat_datapath dp_i (
    .clk(clk), .rstN(rstN), .mode(mode), .prbsSel(prbsSel),
    .byteData(byteData), .byteSel(byteSel), .byteWr(byteWr),
    .strb(strb), .dataOut(dataOut)
  );
endmodule

// File: tb/bert_pattern_gen_tb_top.sv
module bert_pattern_gen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] prbsSel = 3'd0;
  logic [4:0] patLen = 5'd0;
  logic [7:0] altCount = 8'd0;
  logic [7:0] byteData = 8'd0;
  logic [1:0] byteSel = 2'd0;
  logic       byteWr = 1'b0;
  logic       load = 1'b0;
  logic       bitEn = 1'b0;
  logic       dataOut;

  bert_pattern_gen dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .prbsSel(prbsSel), .patLen(patLen),
    .altCount(altCount), .byteData(byteData), .byteSel(byteSel), .byteWr(byteWr),
    .load(load), .bitEn(bitEn), .dataOut(dataOut)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;
  bit  cap [0:8299];

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: output history held in a queue
  logic [31:0] mPat = '0;
  bit          mq[$];
  int          mZeros = 0;
  longint      mK = 0;

  function automatic int ordOf(logic [2:0] s);
    case (s) 3'd0: return 7; 3'd1: return 9; 3'd2: return 11; 3'd3: return 15; default: return 20; endcase
  endfunction
  function automatic int tapOf(logic [2:0] s);
    case (s) 3'd0: return 6; 3'd1: return 5; 3'd2: return 9; 3'd3: return 14; default: return 17; endcase
  endfunction

  function automatic void mInit();
    int n = ordOf(prbsSel);
    mq.delete();
    for (int i = n - 1; i >= 0; i--) mq.push_back(mPat[i]);
    mZeros = 0;
    mK = 0;
  endfunction

  function automatic bit mOut();
    case (mode)
      2'd0: return (prbsSel >= 3'd4 && mZeros >= 14) ? 1'b1 : mq[0];
      2'd1: return mPat[int'(mK % (longint'(patLen) + 1))];
      2'd2: begin
        longint w = mK / 16;
        int b = int'(mK % 16);
        int s = int'((w / (longint'(altCount) + 1)) % 2);
        return mPat[s*16 + b];
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic void mAdvance();
    int n = ordOf(prbsSel);
    int t = tapOf(prbsSel);
    bit o = mOut();
    bit nb;
    if (mode == 2'd0 && prbsSel >= 3'd4) mZeros = o ? 0 : mZeros + 1;
    else mZeros = 0;
    nb = mq[0] ^ mq[n - t];
    void'(mq.pop_front());
    mq.push_back(nb);
    mK++;
  endfunction

  function automatic string tagOf();
    case (mode)
      2'd0: return (prbsSel >= 3'd4) ? "R4" : "R3";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPat = '0;
      mInit();
    end else begin
      if (load) mInit();
      else if (bitEn) mAdvance();
      if (byteWr) mPat[byteSel*8 +: 8] = byteData;
    end
    #5;
    if (!done) check(tagOf(), dataOut, mOut());
  end

  task automatic writeBytes(logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      byteWr = 1'b1; byteSel = 2'(b); byteData = v[b*8 +: 8];
    end
    @(negedge clk);
    byteWr = 1'b0;
  endtask

  task automatic cfgLoad(logic [1:0] m, logic [2:0] s, logic [4:0] len, logic [7:0] cnt);
    @(negedge clk);
    mode = m; prbsSel = s; patLen = len; altCount = cnt; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic emit(output bit b);
    @(negedge clk);
    b = dataOut;
    bitEn = 1'b1;
  endtask

  task automatic stopEn();
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic capture(int n);
    for (int i = 0; i < n; i++) emit(cap[i]);
    stopEn();
  endtask

  task automatic runFree(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitEn = (i % 3 != 2);
    end
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    bit b;
    bit held;
    int cnt;
    int run;
    int maxRun;
    bit exp5 [0:9] = '{1,0,1,1,0,1,0,1,1,0};

    repeat (3) @(negedge clk);
    check("R1", dataOut, 1'b0);
    rstN = 1'b1;

    // R2 / R5: five-bit pattern replicated across four bytes
    writeBytes(32'h5AD6B5AD);
    cfgLoad(2'd1, 3'd0, 5'd4, 8'd0);
    capture(10);
    for (int i = 0; i < 10; i++) check("R2", cap[i], exp5[i]);

    // R8: idle strobe holds the output
    @(negedge clk);
    held = dataOut;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8", dataOut, held);
    end

    // R7: load beats a same-cycle bit-enable
    cfgLoad(2'd1, 3'd0, 5'd4, 8'd0);
    for (int i = 0; i < 3; i++) emit(b);
    @(negedge clk);
    load = 1'b1; bitEn = 1'b1;
    @(negedge clk);
    load = 1'b0; bitEn = 1'b0;
    check("R7", dataOut, 1'b1);
    emit(b);
    stopEn();
    check("R7", dataOut, 1'b0);

    // R5: full 32-bit and single-bit lengths
    writeBytes(32'hC3A51F08);
    cfgLoad(2'd1, 3'd0, 5'd31, 8'd0);
    runFree(100);
    writeBytes(32'h00000001);
    cfgLoad(2'd1, 3'd0, 5'd0, 8'd0);
    runFree(20);
    check("R5", dataOut, 1'b1);

    // R3: pseudorandom orders
    writeBytes(32'hFFFFFFFF);
    cfgLoad(2'd0, 3'd0, 5'd0, 8'd0);
    capture(254);
    cnt = 0;
    for (int i = 0; i < 127; i++) if (cap[i] != cap[i + 127]) cnt++;
    checkInt("R3 period mismatches", cnt, 0);
    cnt = 0;
    for (int i = 0; i < 127; i++) cnt += cap[i];
    checkInt("R3 ones per period", cnt, 64);
    for (int s = 1; s < 4; s++) begin
      cfgLoad(2'd0, 3'(s), 5'd0, 8'd0);
      runFree(300);
    end

    // R7: load with a same-cycle byte write seeds from the old contents
    cfgLoad(2'd0, 3'd0, 5'd0, 8'd0);
    @(negedge clk);
    load = 1'b1; byteWr = 1'b1; byteSel = 2'd0; byteData = 8'h00;
    @(negedge clk);
    load = 1'b0; byteWr = 1'b0;
    capture(7);
    cnt = 0;
    for (int i = 0; i < 7; i++) cnt += cap[i];
    checkInt("R7 seed ones", cnt, 7);

    // R4: zero-limited sequence from a sparse seed
    writeBytes(32'h00000001);
    cfgLoad(2'd0, 3'd4, 5'd0, 8'd0);
    capture(600);
    run = 0; maxRun = 0;
    for (int i = 0; i < 600; i++) begin
      run = cap[i] ? 0 : run + 1;
      if (run > maxRun) maxRun = run;
    end
    checkInt("R4 longest zero run", maxRun, 14);
    writeBytes(32'hFFFFFFFF);
    cfgLoad(2'd0, 3'd4, 5'd0, 8'd0);
    runFree(3000);

    // R6: alternating words, A = 0000, B = 7E7F
    writeBytes(32'h7E7F0000);
    cfgLoad(2'd2, 3'd0, 5'd0, 8'd1);
    capture(100);
    cnt = 0;
    for (int i = 0; i < 32; i++) cnt += cap[i];
    checkInt("R6 word A run", cnt, 0);
    check("R6", cap[32], 1'b1);
    check("R6", cap[64], 1'b0);
    check("R6", cap[96], 1'b1);
    cfgLoad(2'd2, 3'd0, 5'd0, 8'd0);
    runFree(200);
    cfgLoad(2'd2, 3'd0, 5'd0, 8'd255);
    capture(8200);
    check("R6", cap[4080], 1'b0);
    check("R6", cap[4096], 1'b1);
    check("R6", cap[8176], 1'b1);
    check("R6", cap[8192], 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule